// File: doc/BRIEF.md
# Prioritized Interrupt Enable Controller

This block takes 32 interrupt request lines and decides which one should interrupt the core. Each line has an enable bit and a three-bit priority. A rising edge on a request line marks that line pending. Among the lines that are both enabled and pending, the block picks the one with the numerically lowest priority. When two lines share the same priority, the lower line number wins.

The chosen line is offered to the core on a single request output. It is offered only when its priority is strictly lower in value than the priority the core is servicing now. When the core acknowledges, the offered line's pending bit is cleared and its priority is pushed onto a small stack of active priorities. A completion pulse pops that stack. When the stack is empty the core is idle, and any enabled pending line may be offered.

Software reaches the block through a word-addressed register port. The port has separate set-enable and clear-enable words, a read-only pending word, and eight priority words. Each priority word holds four one-byte priority fields.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all enables, pending bits and priorities are zero, no priority is active, and `core_req_o` is low.
- R2: Writing to the set-enable word (address 0x00) sets every enable bit whose data bit is 1 and leaves bits written with 0 unchanged. Reading address 0x00 or 0x01 returns the enable word.
- R3: Writing to the clear-enable word (address 0x01) clears every enable bit whose data bit is 1. Bits written with 0 are left unchanged.
- R4: The priority word k sits at address 0x08+k. Line 4k+j occupies bits 8j+7:8j of that word. Only bits 8j+7:8j+5 are stored; the other bits read as zero. For example, writing 0x00A00000 to address 0x0F gives line 30 priority 5, and that word reads back as 0x00A00000.
- R5: A line's pending bit is set on the clock edge where its request is high and was low at the previous edge, whether or not the line is enabled. The pending word reads at address 0x02, bit n for line n. Writes to that address have no effect.
- R6: Among the lines that are both enabled and pending, the line with the lowest priority value is selected. On a tie, the lowest line number is selected.
- R7: `core_req_o` is high exactly when a line is selected, the active stack is not full, and either no priority is active or the selected priority is numerically lower than the active one. `core_id_o` and `core_prio_o` give that line and its priority.
- R8: An `ack_i` while `core_req_o` is high does two things at the next edge: it clears the offered line's pending bit, and it pushes that line's priority so it becomes the active priority. An `ack_i` while `core_req_o` is low is ignored.
- R9: A `done_i` pulse pops the active stack, so the previous active priority returns, or idle once the stack is empty. A `done_i` with an empty stack is ignored. When `ack_i` and `done_i` arrive in the same cycle, the pop takes effect first and then the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Request level per line |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| ack_i | input | 1 | Core takes the offered line |
| done_i | input | 1 | Core finished the current handler |
| core_req_o | output | 1 | Interrupt request to the core |
| core_id_o | output | 5 | Offered line number |
| core_prio_o | output | 3 | Offered line priority |
| active_valid_o | output | 1 | A handler is active |
| active_prio_o | output | 3 | Priority of the innermost active handler |

## Verification
The assertions check these properties on every cycle:
- a request edge always leaves the pending bit set;
- an acknowledge clears the pending bit unless a new edge arrives at the same time;
- the set-enable and clear-enable words only ever set or only ever clear bits;
- the selected line is an enabled pending line, and no other candidate beats it;
- the stack depth follows pushes and pops.

Other behaviour can only be shown by the bench's scenarios:
- equal-priority requests wait while a handler at that priority is active;
- a lower-priority request preempts the active handler;
- a full stack blocks a request that would otherwise preempt;
- the enable and priority fields read back correctly after arbitrary writes.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned REG_EN_SET    = 0;
  localparam int unsigned REG_EN_CLR    = 1;
  localparam int unsigned REG_PEND      = 2;
  localparam int unsigned REG_PRIO_BASE = 8;
  localparam int unsigned LINES_PER_WORD = 4;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 3,
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [N-1:0]    pend_i,
  output logic [N-1:0]    en_o,
  output logic [N*PW-1:0] prio_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int unsigned NWORDS = N / LINES_PER_WORD;
  localparam int unsigned BYTE_W = DW / LINES_PER_WORD;

  logic [N-1:0]  en_q;
  logic [PW-1:0] prio_q [N];

  wire wr_set = we_i && (addr_i == AW'(REG_EN_SET));
  wire wr_clr = we_i && (addr_i == AW'(REG_EN_CLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (wr_set) en_q <= en_q | wdata_i[N-1:0];
    else if (wr_clr) en_q <= en_q & ~wdata_i[N-1:0];
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    wire wr_prio = we_i && (addr_i == AW'(REG_PRIO_BASE + k));
    for (genvar j = 0; j < LINES_PER_WORD; j++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prio_q[k*LINES_PER_WORD+j] <= '0;
        else if (wr_prio)
          prio_q[k*LINES_PER_WORD+j] <= wdata_i[j*BYTE_W+BYTE_W-1 -: PW];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign prio_o[i*PW +: PW] = prio_q[i];
  end
  assign en_o = en_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(REG_EN_SET) || addr_i == AW'(REG_EN_CLR)) rdata_o[N-1:0] = en_q;
    else if (addr_i == AW'(REG_PEND)) rdata_o[N-1:0] = pend_i;
    for (int k = 0; k < NWORDS; k++) begin
      if (addr_i == AW'(REG_PRIO_BASE + k)) begin
        for (int j = 0; j < LINES_PER_WORD; j++)
          rdata_o[j*BYTE_W+BYTE_W-1 -: PW] = prio_q[k*LINES_PER_WORD+j];
      end
    end
  end

  // R2: a set write never loses a written 1 and never clears a bit
  a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_q & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])) &&
               ((en_q & $past(en_q)) == $past(en_q)));
  // R3: a clear write removes every written 1 and sets nothing
  a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_q & $past(wdata_i[N-1:0])) == '0) &&
               ((en_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          clr_i,
  input  logic [IW-1:0] clr_id_i,
  output logic [N-1:0]  pend_o
);
  logic [N-1:0] irq_q, pend_q, rise, clr_mask;

  assign rise     = irq_i & ~irq_q;
  assign clr_mask = clr_i ? (N'(1) << clr_id_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= (pend_q & ~clr_mask) | rise;
    end
  end
  assign pend_o = pend_q;

  // R5: every observed edge leaves its pending bit set
  a_r5_edge_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(irq_i) & ~$past(irq_q)) & ~pend_q) == '0));
  // R8: acknowledged line is cleared unless a fresh edge arrived
  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise[clr_id_i]) |=> !pend_q[$past(clr_id_i)]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 3,
  parameter int unsigned IW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   id_o,
  output logic [PW-1:0]   prio_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lower index on a tie
      if (cand_i[i] && (!valid_o || prio_i[i*PW +: PW] < prio_o)) begin
        valid_o = 1'b1;
        id_o    = IW'(i);
        prio_o  = prio_i[i*PW +: PW];
      end
    end
  end

  logic beaten;
  always_comb begin
    beaten = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && ((prio_i[i*PW +: PW] < prio_o) ||
          ((prio_i[i*PW +: PW] == prio_o) && (IW'(i) < id_o))))
        beaten = 1'b1;
    end
  end

  // R6: winner is a live candidate and nothing outranks it
  a_r6_winner_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cand_i[id_o]);
  a_r6_none_better: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !beaten);
  a_r6_idle_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i == '0) |-> !valid_o);
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [PW-1:0] data_i,
  output logic          valid_o,
  output logic          full_o,
  output logic [PW-1:0] top_o
);
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned SLOTS = 1 << CW;

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] stk_q [SLOTS];

  wire do_pop  = pop_i && (cnt_q != '0);
  wire do_push = push_i && (!full_o || do_pop);

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign top_o   = valid_o ? stk_q[cnt_q - CW'(1)] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int s = 0; s < SLOTS; s++) stk_q[s] <= '0;
    end else if (do_push && do_pop) begin
      stk_q[cnt_q - CW'(1)] <= data_i;
    end else if (do_push) begin
      stk_q[cnt_q] <= data_i;
      cnt_q        <= cnt_q + CW'(1);
    end else if (do_pop) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R9: a lone completion drops exactly one level
  a_r9_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && valid_o) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R9: completion on an empty stack leaves it empty
  a_r9_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !valid_o) |=> !valid_o);
  // R8: a push becomes the visible top
  a_r8_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> (valid_o && top_o == $past(data_i)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_LINES     = 32,
  parameter int unsigned PRIO_W      = 3,
  parameter int unsigned STACK_DEPTH = 4,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 32,
  localparam int unsigned ID_W       = $clog2(N_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ack_i,
  input  logic              done_i,
  output logic              core_req_o,
  output logic [ID_W-1:0]   core_id_o,
  output logic [PRIO_W-1:0] core_prio_o,
  output logic              active_valid_o,
  output logic [PRIO_W-1:0] active_prio_o
);
  logic [N_LINES-1:0]        en, pend;
  logic [N_LINES*PRIO_W-1:0] prio_flat;
  logic                      sel_valid, stk_full;
  logic [ID_W-1:0]           sel_id;
  logic [PRIO_W-1:0]         sel_prio;

  irq_regs #(.N(N_LINES), .PW(PRIO_W), .AW(ADDR_W), .DW(DATA_W)) regs_i (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .pend_i(pend), .en_o(en), .prio_o(prio_flat), .rdata_o(reg_rdata_o)
  );

  wire take = ack_i && core_req_o;

  irq_pending #(.N(N_LINES), .IW(ID_W)) pend_i (
    .clk_i, .rst_ni, .irq_i, .clr_i(take), .clr_id_i(sel_id), .pend_o(pend)
  );

  irq_arbiter #(.N(N_LINES), .PW(PRIO_W), .IW(ID_W)) arb_i (
    .clk_i, .rst_ni, .cand_i(en & pend), .prio_i(prio_flat),
    .valid_o(sel_valid), .id_o(sel_id), .prio_o(sel_prio)
  );

  irq_prio_stack #(.DEPTH(STACK_DEPTH), .PW(PRIO_W)) stk_i (
    .clk_i, .rst_ni, .push_i(take), .pop_i(done_i), .data_i(sel_prio),
    .valid_o(active_valid_o), .full_o(stk_full), .top_o(active_prio_o)
  );

  assign core_req_o  = sel_valid && !stk_full &&
                       (!active_valid_o || sel_prio < active_prio_o);
  assign core_id_o   = sel_id;
  assign core_prio_o = sel_prio;

  // R8: accepted acknowledge makes the offered priority active
  a_r8_ack_activates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !done_i) |=> (active_valid_o && active_prio_o == $past(core_prio_o)));
  // R7: an offered line is enabled and pending
  a_r7_offer_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_req_o |-> (en[core_id_o] && pend[core_id_o]));
  // R1: nothing is active right after reset release
  a_r1_idle_after_reset: assert property (@(posedge clk_i)
    !rst_ni |=> !active_valid_o);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack = 1'b0, done = 1'b0;
  logic        req, act_v;
  logic [4:0]  id;
  logic [2:0]  prio, act_p;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack), .done_i(done),
    .core_req_o(req), .core_id_o(id), .core_prio_o(prio),
    .active_valid_o(act_v), .active_prio_o(act_p)
  );

  int n_chk = 0, n_fail = 0;

  // reference state
  logic [31:0] m_en, m_pend, m_irq_q;
  logic [2:0]  m_prio [32];
  logic [2:0]  m_stk [4];
  int          m_depth;
  logic        m_req;
  logic [4:0]  m_id;
  logic [2:0]  m_sel;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_eval();
    logic found = 1'b0;
    m_id = '0; m_sel = '0;
    for (int i = 0; i < 32; i++)
      if (m_en[i] && m_pend[i] && (!found || m_prio[i] < m_sel)) begin
        found = 1'b1; m_id = 5'(i); m_sel = m_prio[i];
      end
    m_req = found && (m_depth < 4) && (m_depth == 0 || m_sel < m_stk[m_depth-1]);
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    logic [31:0] r = '0;
    if (a == 6'd0 || a == 6'd1) r = m_en;
    else if (a == 6'd2) r = m_pend;
    else if (a >= 6'd8 && a <= 6'd15)
      for (int j = 0; j < 4; j++) r[8*j+7 -: 3] = m_prio[(a-8)*4+j];
    return r;
  endfunction

  function automatic void model_clear();
    m_en = '0; m_pend = '0; m_irq_q = '0; m_depth = 0;
    for (int i = 0; i < 32; i++) m_prio[i] = '0;
    for (int i = 0; i < 4; i++) m_stk[i] = '0;
    model_eval();
  endfunction

  task automatic compare();
    chk("R7 core_req", {31'd0, req}, {31'd0, m_req});
    if (m_req) begin
      chk("R6 core_id", {27'd0, id}, {27'd0, m_id});
      chk("R6 core_prio", {29'd0, prio}, {29'd0, m_sel});
    end
    chk("R9 active_valid", {31'd0, act_v}, {31'd0, m_depth != 0});
    if (m_depth != 0) chk("R9 active_prio", {29'd0, act_p}, {29'd0, m_stk[m_depth-1]});
    if (addr == 6'd2) chk("R5 pend read", rdata, model_read(addr));
    else if (addr >= 6'd8) chk("R4 prio read", rdata, model_read(addr));
    else chk("R2 en read", rdata, model_read(addr));
  endtask

  task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d,
                      input logic [31:0] rq, input logic ak, input logic dn);
    logic        ackv;
    logic [31:0] clr;
    we = w; addr = a; wdata = d; irq = rq; ack = ak; done = dn;
    @(posedge clk);
    ackv = ak && m_req;
    clr  = ackv ? (32'd1 << m_id) : '0;
    m_pend  = (m_pend & ~clr) | (rq & ~m_irq_q);
    m_irq_q = rq;
    if (w) begin
      if (a == 6'd0) m_en = m_en | d;
      else if (a == 6'd1) m_en = m_en & ~d;
      else if (a >= 6'd8 && a <= 6'd15)
        for (int j = 0; j < 4; j++) m_prio[(a-8)*4+j] = d[8*j+7 -: 3];
    end
    if (dn && m_depth > 0 && ackv) m_stk[m_depth-1] = m_sel;
    else if (ackv) begin m_stk[m_depth] = m_sel; m_depth++; end
    else if (dn && m_depth > 0) m_depth--;
    model_eval();
    #1;
    we = 1'b0; ack = 1'b0; done = 1'b0;
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; we = 1'b0; ack = 1'b0; done = 1'b0; addr = '0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_0b1a));

    // reset state and full stack
    do_reset();
    chk("R1 req", {31'd0, req}, 32'd0);
    chk("R1 active", {31'd0, act_v}, 32'd0);
    step(0, 6'd0, 0, 0, 0, 0);  chk("R1 en", rdata, 32'd0);
    step(0, 6'd2, 0, 0, 0, 0);  chk("R1 pend", rdata, 32'd0);
    step(0, 6'd15, 0, 0, 0, 0); chk("R1 prio", rdata, 32'd0);
    step(1, 6'd8, 32'h204080C0, 0, 0, 0);
    step(1, 6'd0, 32'h1F, 0, 0, 0);
    r = 32'h1;
    step(0, 6'd2, 0, r, 0, 0);
    chk("R7 first offer id", {27'd0, id}, 32'd0);
    chk("R7 first offer prio", {29'd0, prio}, 32'd6);
    step(0, 6'd2, 0, r, 1, 0);
    chk("R8 active prio", {29'd0, act_p}, 32'd6);
    chk("R8 pend cleared", rdata, 32'd0);
    for (int b = 1; b < 4; b++) begin
      r = r | (32'd1 << b);
      step(0, 6'd2, 0, r, 0, 0);
      chk("R7 preempt offer", {31'd0, req}, 32'd1);
      step(0, 6'd2, 0, r, 1, 0);
    end
    chk("R8 fourth active", {29'd0, act_p}, 32'd1);
    r = r | 32'h10;
    step(0, 6'd2, 0, r, 0, 0);
    chk("R7 full blocks", {31'd0, req}, 32'd0);
    step(0, 6'd2, 0, r, 0, 1);
    chk("R9 pop restores", {29'd0, act_p}, 32'd2);
    chk("R7 offer after pop", {27'd0, id}, 32'd4);

    // register map, tie-break, preemption
    do_reset();
    step(1, 6'd15, 32'hFFFFFFFF, 0, 0, 0); chk("R4 unimpl bits zero", rdata, 32'hE0E0E0E0);
    step(1, 6'd15, 32'h00A00000, 0, 0, 0); chk("R4 line30 prio5", rdata, 32'h00A00000);
    step(1, 6'd0, 32'h40000000, 0, 0, 0);
    step(0, 6'd1, 0, 0, 0, 0);             chk("R2 en via clr addr", rdata, 32'h40000000);
    step(1, 6'd0, 32'h0, 0, 0, 0);         chk("R2 zero no effect", rdata, 32'h40000000);
    r = 32'h40000000;
    step(0, 6'd2, 0, r, 0, 0);
    chk("R5 pend set", rdata, 32'h40000000);
    chk("R7 id30", {27'd0, id}, 32'd30);
    chk("R7 prio5", {29'd0, prio}, 32'd5);
    step(1, 6'd8, 32'hA0000000, r, 0, 0);
    step(1, 6'd0, 32'h8, r, 0, 0);
    r = r | 32'h8;
    step(0, 6'd2, 0, r, 0, 0);
    chk("R6 tie lower index", {27'd0, id}, 32'd3);
    step(0, 6'd2, 0, r, 1, 0);
    chk("R8 active5", {29'd0, act_p}, 32'd5);
    chk("R7 equal waits", {31'd0, req}, 32'd0);
    step(1, 6'd10, 32'h00000040, r, 0, 0);
    step(1, 6'd0, 32'h100, r, 0, 0);
    r = r | 32'h100;
    step(0, 6'd2, 0, r, 0, 0);
    chk("R7 lower preempts", {27'd0, id}, 32'd8);
    step(0, 6'd2, 0, r, 1, 0);
    chk("R8 active2", {29'd0, act_p}, 32'd2);
    step(0, 6'd2, 0, r, 0, 1);
    chk("R9 back to 5", {29'd0, act_p}, 32'd5);
    step(0, 6'd2, 0, r, 0, 1);
    chk("R9 idle", {31'd0, act_v}, 32'd0);
    chk("R9 offer after idle", {27'd0, id}, 32'd30);
    step(1, 6'd1, 32'h40000000, r, 0, 0);
    chk("R3 disabled no req", {31'd0, req}, 32'd0);
    step(0, 6'd0, 0, r, 0, 0);
    chk("R3 en word", rdata, 32'h00000108);
    step(0, 6'd2, 0, r, 0, 1);
    chk("R9 empty done ignored", {31'd0, act_v}, 32'd0);
    r = r | 32'h00100000;
    step(1, 6'd2, 32'hFFFFFFFF, r, 1, 0);
    step(0, 6'd2, 0, r, 0, 0);
    chk("R5 pend without enable", rdata, 32'h40100000);
    chk("R8 ack ignored without req", {31'd0, act_v}, 32'd0);

    // random phase
    do_reset();
    r = '0;
    for (int c = 0; c < 4000; c++) begin
      logic [5:0]  a;
      logic [31:0] d;
      logic        w;
      r = r ^ ($urandom() & $urandom() & $urandom() & $urandom());
      w = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 3))
        0: a = 6'd0;
        1: a = 6'd1;
        2: a = 6'd2;
        default: a = 6'(8 + $urandom_range(0, 7));
      endcase
      d = (a == 6'd1) ? ($urandom() & $urandom() & $urandom()) : $urandom();
      step(w, a, d, r, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
    end
    finish_run();
  end
endmodule